// File: doc/BRIEF.md
# Dual-Bank Radix-4 Remainder Step

This block performs one radix-4 step of a digit-recurrence divider while hiding the delay of quotient-digit selection. The partial remainder arrives in carry-save form as two words. It is shifted left by two places, which multiplies it by four. Two carry-save adder banks then work on it side by side. The first bank subtracts either nothing or one divisor. That choice comes from an early magnitude indication that is settled well before the digit table finishes. The second bank always subtracts twice the divisor. When the late table output arrives, a wide multiplexer picks one of the two banks. The chosen carry-save pair is registered as the next remainder.

A negative digit adds the divisor multiple instead of subtracting it. A positive, non-zero digit subtracts by inverting the multiple and injecting a one into the free least-significant bit of the carry word. No carry ever ripples across the word inside the step. The remainder words carry guard bits above the divisor width, and all arithmetic wraps modulo two to the power of the word width. An enclosing divider feeds the registered pair back as the next input. It supplies the three digit lines and pulses the step enable once per iteration.

Top module: `srt2b_stage`

## Requirements
- R1: When `stepEn` is high at a rising edge, the sum of `remSumOut` and `remCarryOut` taken modulo 2^(WIDTH+GUARD) becomes 4·(remSumIn + remCarryIn) − q·divisor. Here q is the signed digit given by the three digit inputs.
- R2: With `qTwoLate` low, the digit magnitude is 1 when `qOneEarly` is high and 0 when it is low.
- R3: When `qTwoLate` is high, the digit magnitude is 2 and `qOneEarly` has no effect on the result.
- R4: After a step, `remCarryOut[0]` is 1 exactly when the digit is positive (`qNeg` low) and non-zero. In every other case it is 0.
- R5: When `stepEn` is low at a rising edge, both outputs keep their values whatever the other inputs do.
- R6: While `rstN` is low, both output words are zero.
- R7: A zero-magnitude digit gives 4·(remSumIn + remCarryIn) whatever the level of `qNeg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| stepEn | input | 1 | Capture the next remainder at this edge |
| remSumIn | input | WIDTH+GUARD | Sum word of the current remainder |
| remCarryIn | input | WIDTH+GUARD | Carry word of the current remainder |
| divisor | input | WIDTH | Divisor, unsigned |
| qNeg | input | 1 | Digit sign, 1 = negative |
| qOneEarly | input | 1 | Early magnitude line, 1 = magnitude one |
| qTwoLate | input | 1 | Late table line, 1 = magnitude two, selects the second bank |
| remSumOut | output | WIDTH+GUARD | Registered sum word of the next remainder |
| remCarryOut | output | WIDTH+GUARD | Registered carry word of the next remainder |

## Verification
A wrong bank choice, a lost or extra carry injection, or a bad shift shows up one cycle later. It appears as a residue of the output pair that differs from 4·remainder − q·divisor. The bench therefore compares the residue of the pair after every step, not the individual words. A stray capture while the enable is low shows as an output change on that same following edge. A fault in the injection bit is also seen directly on the least-significant carry bit.

// File: rtl/srt2b_pkg.sv
package srt2b_pkg;
  typedef struct packed {
    logic capture;
    logic negate;
    logic doOne;
    logic pickTwo;
  } stepCtl_t;
endpackage

// File: rtl/srt2b_ctrl.sv
module srt2b_ctrl
  import srt2b_pkg::*;
(
  input  logic     stepEn,
  input  logic     qNeg,
  input  logic     qOneEarly,
  input  logic     qTwoLate,
  output stepCtl_t ctl
);
  always_comb begin
    ctl.capture = stepEn;
    ctl.negate  = qNeg;
    ctl.doOne   = qOneEarly;   // early: feeds bank A before the table settles
    ctl.pickTwo = qTwoLate;    // late: only drives the wide output mux
  end
endmodule

// File: rtl/srt2b_csa_bank.sv
module srt2b_csa_bank #(
  parameter int TW = 59
) (
  input  logic [TW-1:0] shSum,
  input  logic [TW-1:0] shCarry,
  input  logic [TW-1:0] multiple,
  input  logic          invert,
  output logic [TW-1:0] bankSum,
  output logic [TW-1:0] bankCarry
);
  logic [TW-1:0] addend;
  logic [TW-1:0] majority;

  always_comb begin
    addend    = invert ? ~multiple : multiple;
    bankSum   = shSum ^ shCarry ^ addend;
    majority  = (shSum & shCarry) | (shSum & addend) | (shCarry & addend);
    bankCarry = {majority[TW-2:0], invert};  // injected +1 completes the negation
  end
endmodule

// File: rtl/srt2b_datapath.sv
module srt2b_datapath
  import srt2b_pkg::*;
#(
  parameter int WIDTH = 56,
  parameter int GUARD = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stepCtl_t               ctl,
  input  logic [WIDTH+GUARD-1:0] remSumIn,
  input  logic [WIDTH+GUARD-1:0] remCarryIn,
  input  logic [WIDTH-1:0]       divisor,
  output logic [WIDTH+GUARD-1:0] remSumOut,
  output logic [WIDTH+GUARD-1:0] remCarryOut
);
  localparam int TW    = WIDTH + GUARD;
  localparam int NBANK = 2;

  logic [TW-1:0] shSum, shCarry, divExt;
  logic [TW-1:0] bankSum   [NBANK];
  logic [TW-1:0] bankCarry [NBANK];
  logic [TW-1:0] nextSum, nextCarry;

  assign shSum   = {remSumIn[TW-3:0], 2'b00};
  assign shCarry = {remCarryIn[TW-3:0], 2'b00};
  assign divExt  = {{GUARD{1'b0}}, divisor};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [TW-1:0] mult;
    logic          inv;
    if (b == 0) begin : g_zero_one
      assign mult = ctl.doOne ? divExt : '0;
      assign inv  = ctl.doOne & ~ctl.negate;
    end else begin : g_two
      assign mult = {divExt[TW-2:0], 1'b0};
      assign inv  = ~ctl.negate;
    end
    srt2b_csa_bank #(.TW(TW)) bank_i (
      .shSum    (shSum),
      .shCarry  (shCarry),
      .multiple (mult),
      .invert   (inv),
      .bankSum  (bankSum[b]),
      .bankCarry(bankCarry[b])
    );
  end

  assign nextSum   = ctl.pickTwo ? bankSum[1]   : bankSum[0];
  assign nextCarry = ctl.pickTwo ? bankCarry[1] : bankCarry[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remSumOut   <= '0;
      remCarryOut <= '0;
    end else if (ctl.capture) begin
      remSumOut   <= nextSum;
      remCarryOut <= nextCarry;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(remSumOut) && $stable(remCarryOut)));

  p_reset_clear_r6: assert property (@(posedge clk)
    !rstN |=> (remSumOut == '0 && remCarryOut == '0));

  p_inject_pos_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.negate && (ctl.doOne || ctl.pickTwo)) |=> remCarryOut[0]);

  p_inject_none_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && (ctl.negate || !(ctl.doOne || ctl.pickTwo))) |=> !remCarryOut[0]);
endmodule

// File: rtl/srt2b_stage.sv
module srt2b_stage
  import srt2b_pkg::*;
#(
  parameter int WIDTH = 56,
  parameter int GUARD = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stepEn,
  input  logic [WIDTH+GUARD-1:0] remSumIn,
  input  logic [WIDTH+GUARD-1:0] remCarryIn,
  input  logic [WIDTH-1:0]       divisor,
  input  logic                   qNeg,
  input  logic                   qOneEarly,
  input  logic                   qTwoLate,
  output logic [WIDTH+GUARD-1:0] remSumOut,
  output logic [WIDTH+GUARD-1:0] remCarryOut
);
  stepCtl_t ctl;

  srt2b_ctrl ctrl_i (
    .stepEn   (stepEn),
    .qNeg     (qNeg),
    .qOneEarly(qOneEarly),
    .qTwoLate (qTwoLate),
    .ctl      (ctl)
  );

  srt2b_datapath #(.WIDTH(WIDTH), .GUARD(GUARD)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .remSumIn   (remSumIn),
    .remCarryIn (remCarryIn),
    .divisor    (divisor),
    .remSumOut  (remSumOut),
    .remCarryOut(remCarryOut)
  );
endmodule

// File: tb/srt2b_stage_tb_top.sv
module srt2b_stage_tb_top;
  localparam int WIDTH = 56;
  localparam int GUARD = 3;
  localparam int TW    = WIDTH + GUARD;

  typedef struct {
    logic [TW-1:0] tot;
    logic          lsb;
    string         req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepEn = 1'b0;
  logic [TW-1:0] remSumIn = '0, remCarryIn = '0;
  logic [WIDTH-1:0] divisor = '0;
  logic qNeg = 1'b0, qOneEarly = 1'b0, qTwoLate = 1'b0;
  logic [TW-1:0] remSumOut, remCarryOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  expItem_t sb[$];
  logic [TW-1:0] prevTot = '0;
  logic prevLsb = 1'b0;

  always #2.5 clk = ~clk;

  srt2b_stage #(.WIDTH(WIDTH), .GUARD(GUARD)) dut_i (
    .clk(clk), .rstN(rstN), .stepEn(stepEn),
    .remSumIn(remSumIn), .remCarryIn(remCarryIn), .divisor(divisor),
    .qNeg(qNeg), .qOneEarly(qOneEarly), .qTwoLate(qTwoLate),
    .remSumOut(remSumOut), .remCarryOut(remCarryOut)
  );

  function automatic logic [TW-1:0] refTot(input logic [TW-1:0] s, input logic [TW-1:0] c,
                                           input logic [WIDTH-1:0] d, input logic neg,
                                           input logic one, input logic two);
    logic [63:0] mag, prod, base;
    mag  = two ? 64'd2 : (one ? 64'd1 : 64'd0);
    prod = mag * {8'd0, d};
    base = ({5'd0, s} + {5'd0, c}) << 2;
    return neg ? TW'(base + prod) : TW'(base - prod);
  endfunction

  task automatic drive(input logic st, input logic [TW-1:0] s, input logic [TW-1:0] c,
                       input logic [WIDTH-1:0] d, input logic neg, input logic one,
                       input logic two, input string req);
    expItem_t it;
    @(negedge clk);
    stepEn = st; remSumIn = s; remCarryIn = c; divisor = d;
    qNeg = neg; qOneEarly = one; qTwoLate = two;
    if (st) begin
      prevTot = refTot(s, c, d, neg, one, two);
      prevLsb = !neg && (one || two);
    end
    it.tot = prevTot; it.lsb = prevLsb; it.req = st ? req : "R5";
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      expItem_t it;
      logic [TW-1:0] got;
      it = sb.pop_front();
      got = remSumOut + remCarryOut;
      checks++;
      if (got !== it.tot) begin
        fails++;
        $display("FAIL %s residue actual=%h expected=%h", it.req, got, it.tot);
      end
      checks++;
      if (remCarryOut[0] !== it.lsb) begin
        fails++;
        $display("FAIL R4 (%s) carry lsb actual=%b expected=%b", it.req, remCarryOut[0], it.lsb);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] s0, c0;
    logic [WIDTH-1:0] d0;
    s0 = 59'h0123456789ABCD;
    c0 = 59'h00FEDCBA987654;
    d0 = 56'h9A3C5F00112233;
    repeat (3) @(negedge clk);
    checks++;  // R6 reset state
    if (remSumOut !== '0 || remCarryOut !== '0) begin
      fails++;
      $display("FAIL R6 reset actual=%h/%h expected=0/0", remSumOut, remCarryOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;  // R6 held after release with no step
    if (remSumOut !== '0 || remCarryOut !== '0) begin
      fails++;
      $display("FAIL R6 post-release actual=%h/%h expected=0/0", remSumOut, remCarryOut);
    end
    drive(1, s0, c0, d0, 0, 1, 0, "R2");
    drive(1, s0, c0, d0, 1, 1, 0, "R2");
    drive(1, s0, c0, d0, 0, 0, 1, "R3");
    drive(1, s0, c0, d0, 1, 0, 1, "R3");
    drive(1, s0, c0, d0, 0, 0, 0, "R7");
    drive(1, s0, c0, d0, 1, 0, 0, "R7");
    drive(1, s0, c0, d0, 0, 1, 1, "R3");
    drive(1, s0, c0, d0, 1, 1, 1, "R3");
    drive(0, ~s0, c0, ~d0, 0, 1, 0, "R5");
    drive(0, '1, '1, '1, 1, 1, 1, "R5");
    drive(1, '1, '1, '1, 0, 0, 1, "R1");
    for (int i = 0; i < 60; i++) begin
      logic [TW-1:0] rs, rc;
      logic [WIDTH-1:0] rd;
      rs = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      drive(($urandom % 4) != 0, rs, rc, rd, $urandom % 2, $urandom % 2, $urandom % 2, "R1");
    end
    drive(0, '0, '0, '0, 0, 0, 0, "R5");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule